// File: doc/BRIEF.md
# Quad SPI Flash Controller

This block connects a system bus to a serial NOR flash over one shared serial engine, which has two users. The first is a direct read port. A bus master presents a 24-bit byte address and gets back one 32-bit word as if the flash were plain memory. The controller builds the whole flash transaction on its own: it sends the read opcode, sends the address, waits the dummy clocks, then shifts in four data bytes. The second user is a manual port. Software holds chip select low through a control level and exchanges raw bytes with the flash one at a time. This lets it issue any flash command, such as reading the ID or status.

The read opcode, the number of dummy clocks, the lane mode (one, two or four data lanes) and the serial clock divider are held in one configuration word. A build-time parameter picks whether the reset value describes a single-lane read or a quad-lane read. The serial clock is always an even division of the system clock, and the reset setting divides by four. The flash pads are reached through separate output, output-enable and input vectors, so the pad ring keeps the tri-state buffers.

Top module: `qspi_flash_ctrl`

## Requirements
- R1: After reset, `flash_cs_n` is 1, `flash_sck` is 0, `busy` is 0 and `rd_ready` is 1. With `DEFAULT_QUAD`=0 the configuration resets to single lane, opcode 0x03, no dummy clocks and half-period 2, so a read issued before any configuration write uses those settings.
- R2: A direct read is accepted in a cycle where `rd_req` and `rd_ready` are both high. `flash_cs_n` goes low on the next cycle. The opcode is sent MSB first on lane 0 over 8 clocks, whatever the lane mode. The 24-bit address follows, MSB first, on the configured lanes. Once the data has been read, `rd_valid` pulses for one cycle. `rd_data` then holds the first received byte (at the address) in bits [7:0], the next byte (address+1) in [15:8], and so on up to [31:24].
- R3: The lane field selects the mode: 0 is single, 1 is dual, 2 or 3 is quad. In single mode the controller sends on io0 and receives on io1. In dual mode each clock carries {io1,io0}, with io1 as the more significant bit. In quad mode each clock carries {io3,io2,io1,io0}. A read therefore takes 24/N address clocks and 32/N data clocks for N lanes.
- R4: Each SCK high and low phase lasts exactly `half` system clocks. A `half` value of 0 behaves as 1, so the division is always even and never less than 2.
- R5: SCK idles low. Data outputs change only when SCK falls or a transfer starts, and never while SCK is high (SPI mode 0).
- R6: Between the address and the data, the controller inserts exactly `dummy` clocks with the output enables of io0 and io1 off (all four off in quad mode). A value of 0 means there is no dummy phase.
- R7: A manual write sends the byte MSB first on io0 over 8 clocks. Meanwhile the controller shifts in io1. It then pulses `man_done` for one cycle with the received byte on `man_rdata`. `rd_valid` and `man_done` never pulse in the same cycle.
- R8: While `man_cs_en` is 1, `flash_cs_n` stays low, including between manual bytes. When `man_cs_en` is 0 and the engine is idle, `flash_cs_n` is high.
- R9: While `man_cs_en` is 1, or a manual byte is in flight or held, `rd_ready` is 0. A pending `rd_req` then starts no read.
- R10: A manual write made while the engine is busy is held in a one-byte slot, and `busy` stays 1. The byte is sent as soon as the engine goes idle, before any new direct read.
- R11: `cfg_we` loads `cfg_wdata` as follows: [7:0] read opcode, [11:8] dummy clocks, [15:12] SCK half-period, [17:16] lane mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 18 | Configuration word |
| rd_req | input | 1 | Direct read request |
| rd_addr | input | 24 | Direct read byte address |
| rd_ready | output | 1 | Direct read can be accepted |
| rd_valid | output | 1 | Direct read data valid pulse |
| rd_data | output | 32 | Direct read word, first byte lowest |
| man_cs_en | input | 1 | Manual chip-select hold level |
| man_wr | input | 1 | Manual byte write strobe |
| man_wdata | input | 8 | Manual byte to send |
| man_done | output | 1 | Manual byte finished pulse |
| man_rdata | output | 8 | Byte received during manual transfer |
| busy | output | 1 | Engine active or byte held |
| flash_sck | output | 1 | Serial clock |
| flash_cs_n | output | 1 | Chip select, active low |
| flash_io_o | output | 4 | Data lane outputs |
| flash_io_oe | output | 4 | Data lane output enables |
| flash_io_i | input | 4 | Data lane inputs |

## Verification
The bench contains a flash model. It records the opcode and the address the controller sends, and it answers from a computed byte pattern, so every returned word depends on the address the model actually received. Direct reads are tried in single, dual and quad mode, and with lane code 3. They cover several dummy counts including zero, several half-periods including zero, and addresses that carry across byte boundaries. Together these separate lane-bit ordering, clock counts per phase, the dummy window and the divider. Manual tests exchange bytes under a held chip select, hold a direct request off, and post a write in the middle of a read, which separates the stall path from the held-byte path.

// File: rtl/qspi_pkg.sv
`timescale 1ns/1ps
package qspi_pkg;

  localparam int CFG_W = 18;

  // Field layout matches cfg_wdata bit positions (MSB first).
  typedef struct packed {
    logic [1:0] lanes;
    logic [3:0] half;
    logic [3:0] dummy;
    logic [7:0] opcode;
  } cfg_t;

  // Lanes carried per serial clock for a lane-mode code.
  function automatic int unsigned lane_width(logic [1:0] mode);
    case (mode)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

  // Serial clocks needed to move a number of bits in a lane mode.
  function automatic int unsigned phase_clks(int unsigned bits, logic [1:0] mode);
    return bits / lane_width(mode);
  endfunction

  // Half-period in system clocks, zero promoted to one.
  function automatic logic [3:0] eff_half(logic [3:0] h);
    return (h == 4'd0) ? 4'd1 : h;
  endfunction

  // Input bits gathered on one rising edge, right-aligned.
  function automatic logic [3:0] gather_in(logic [1:0] mode, logic [3:0] io);
    case (mode)
      2'd0:    return {3'b000, io[1]};
      2'd1:    return {2'b00, io[1:0]};
      default: return io;
    endcase
  endfunction

endpackage

// File: rtl/qspi_cfg_regs.sv
`timescale 1ns/1ps
module qspi_cfg_regs
  import qspi_pkg::*;
#(
  parameter bit         DEFAULT_QUAD = 1'b0,
  parameter logic [3:0] DEFAULT_HALF = 4'd2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output cfg_t             cfg
);

  localparam cfg_t RESET_CFG = '{
    lanes:  DEFAULT_QUAD ? 2'd2 : 2'd0,
    half:   DEFAULT_HALF,
    dummy:  DEFAULT_QUAD ? 4'd6 : 4'd0,
    opcode: DEFAULT_QUAD ? 8'hEB : 8'h03
  };

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg <= RESET_CFG;
    else if (cfg_we) cfg <= cfg_t'(cfg_wdata);
  end

endmodule

// File: rtl/qspi_sck_engine.sv
`timescale 1ns/1ps
module qspi_sck_engine
  import qspi_pkg::*;
#(
  parameter int SR_W  = 32,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SR_W-1:0]  ld_tx,
  input  logic [CNT_W-1:0] ld_nclk,
  input  logic [1:0]       ld_lanes,
  input  logic             ld_oe,
  input  logic [3:0]       half,
  input  logic [3:0]       io_i,
  output logic             sck,
  output logic [3:0]       io_o,
  output logic [3:0]       io_oe,
  output logic [SR_W-1:0]  rx,
  output logic             phase_end
);

  logic [SR_W-1:0]  tx;
  logic [CNT_W-1:0] nclk;
  logic [1:0]       lanes;
  logic             oe;
  logic             active;
  logic [3:0]       div_cnt;
  logic             tick;

  assign tick      = active && (div_cnt == eff_half(half) - 4'd1);
  assign phase_end = tick && sck && (nclk == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx <= '0; rx <= '0; nclk <= '0; lanes <= '0; oe <= 1'b0;
      active <= 1'b0; div_cnt <= '0; sck <= 1'b0;
    end else if (load) begin
      tx <= ld_tx; nclk <= ld_nclk; lanes <= ld_lanes; oe <= ld_oe;
      active <= 1'b1; div_cnt <= '0; sck <= 1'b0;
    end else if (active) begin
      if (!tick) begin
        div_cnt <= div_cnt + 4'd1;
      end else begin
        div_cnt <= '0;
        if (!sck) begin
          sck <= 1'b1;
          rx  <= (rx << lane_width(lanes)) | SR_W'(gather_in(lanes, io_i));
        end else begin
          sck  <= 1'b0;
          tx   <= tx << lane_width(lanes);
          nclk <= nclk - CNT_W'(1);
          if (nclk == CNT_W'(1)) active <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    io_o  = '0;
    io_oe = '0;
    if (active) begin
      case (lanes)
        2'd0: begin
          io_o  = {2'b11, 1'b0, tx[SR_W-1]};
          io_oe = {2'b11, 1'b0, oe};
        end
        2'd1: begin
          io_o  = {2'b11, tx[SR_W-1 -: 2]};
          io_oe = {2'b11, oe, oe};
        end
        default: begin
          io_o  = tx[SR_W-1 -: 4];
          io_oe = {4{oe}};
        end
      endcase
    end
  end

  assert_data_still_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(io_o));

  assert_sck_rests_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sck);

endmodule

// File: rtl/qspi_flash_ctrl.sv
`timescale 1ns/1ps
module qspi_flash_ctrl
  import qspi_pkg::*;
#(
  parameter bit         DEFAULT_QUAD = 1'b0,
  parameter logic [3:0] DEFAULT_HALF = 4'd2,
  parameter int         ADDR_W       = 24,
  parameter int         DATA_BYTES   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [CFG_W-1:0]        cfg_wdata,
  input  logic                    rd_req,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic                    rd_ready,
  output logic                    rd_valid,
  output logic [8*DATA_BYTES-1:0] rd_data,
  input  logic                    man_cs_en,
  input  logic                    man_wr,
  input  logic [7:0]              man_wdata,
  output logic                    man_done,
  output logic [7:0]              man_rdata,
  output logic                    busy,
  output logic                    flash_sck,
  output logic                    flash_cs_n,
  output logic [3:0]              flash_io_o,
  output logic [3:0]              flash_io_oe,
  input  logic [3:0]              flash_io_i
);

  localparam int DATA_W = 8 * DATA_BYTES;
  localparam int SR_W   = DATA_W;
  localparam int CNT_W  = $clog2(DATA_W + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_OPC, ST_ADDR, ST_DUMMY, ST_DATA, ST_MAN} st_t;

  // Received stream is first-byte-high; the bus wants first byte lowest.
  function automatic logic [DATA_W-1:0] first_byte_low(logic [DATA_W-1:0] s);
    logic [DATA_W-1:0] o;
    for (int b = 0; b < DATA_BYTES; b++) o[8*b +: 8] = s[DATA_W-8-8*b +: 8];
    return o;
  endfunction

  cfg_t              cfg;
  st_t               state;
  logic [ADDR_W-1:0] addr_q;
  logic              pend_v;
  logic [7:0]        pend_byte;
  logic              take_pend, start_man, start_rd;
  logic              load, ld_oe, phase_end;
  logic [SR_W-1:0]   ld_tx, rx;
  logic [CNT_W-1:0]  ld_nclk;
  logic [1:0]        ld_lanes;

  qspi_cfg_regs #(.DEFAULT_QUAD(DEFAULT_QUAD), .DEFAULT_HALF(DEFAULT_HALF)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg(cfg)
  );

  qspi_sck_engine #(.SR_W(SR_W), .CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_tx(ld_tx), .ld_nclk(ld_nclk),
    .ld_lanes(ld_lanes), .ld_oe(ld_oe), .half(cfg.half), .io_i(flash_io_i),
    .sck(flash_sck), .io_o(flash_io_o), .io_oe(flash_io_oe), .rx(rx),
    .phase_end(phase_end)
  );

  assign take_pend  = (state == ST_IDLE) && pend_v;
  assign start_man  = (state == ST_IDLE) && (pend_v || man_wr);
  assign rd_ready   = (state == ST_IDLE) && !man_cs_en && !pend_v && !man_wr;
  assign start_rd   = rd_req && rd_ready;
  assign busy       = (state != ST_IDLE) || pend_v;
  assign flash_cs_n = !((state != ST_IDLE) || man_cs_en);
  assign load       = start_man || start_rd ||
                      (phase_end && (state inside {ST_OPC, ST_ADDR, ST_DUMMY}));

  always_comb begin
    ld_tx    = '0;
    ld_nclk  = '0;
    ld_lanes = 2'd0;
    ld_oe    = 1'b0;
    case (state)
      ST_IDLE: begin
        ld_nclk = CNT_W'(8);
        ld_oe   = 1'b1;
        if (start_man) ld_tx = {(pend_v ? pend_byte : man_wdata), {(SR_W-8){1'b0}}};
        else           ld_tx = {cfg.opcode, {(SR_W-8){1'b0}}};
      end
      ST_OPC: begin
        ld_tx    = {addr_q, {(SR_W-ADDR_W){1'b0}}};
        ld_nclk  = CNT_W'(phase_clks(ADDR_W, cfg.lanes));
        ld_lanes = cfg.lanes;
        ld_oe    = 1'b1;
      end
      ST_ADDR: begin
        ld_lanes = cfg.lanes;
        ld_nclk  = (cfg.dummy != 4'd0) ? CNT_W'(cfg.dummy)
                                       : CNT_W'(phase_clks(DATA_W, cfg.lanes));
      end
      ST_DUMMY: begin
        ld_lanes = cfg.lanes;
        ld_nclk  = CNT_W'(phase_clks(DATA_W, cfg.lanes));
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; addr_q <= '0; pend_v <= 1'b0; pend_byte <= '0;
      rd_valid <= 1'b0; rd_data <= '0; man_done <= 1'b0; man_rdata <= '0;
    end else begin
      rd_valid <= 1'b0;
      man_done <= 1'b0;
      if (take_pend) pend_v <= 1'b0;
      if (man_wr && !((state == ST_IDLE) && !pend_v)) begin
        pend_v    <= 1'b1;
        pend_byte <= man_wdata;
      end
      case (state)
        ST_IDLE: begin
          if (start_man) state <= ST_MAN;
          else if (start_rd) begin
            state  <= ST_OPC;
            addr_q <= rd_addr;
          end
        end
        ST_OPC:   if (phase_end) state <= ST_ADDR;
        ST_ADDR:  if (phase_end) state <= (cfg.dummy != 4'd0) ? ST_DUMMY : ST_DATA;
        ST_DUMMY: if (phase_end) state <= ST_DATA;
        ST_DATA: if (phase_end) begin
          state    <= ST_IDLE;
          rd_valid <= 1'b1;
          rd_data  <= first_byte_low(rx);
        end
        ST_MAN: if (phase_end) begin
          state     <= ST_IDLE;
          man_done  <= 1'b1;
          man_rdata <= rx[7:0];
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_cs_follows_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_ready) |=> !flash_cs_n);

  assert_no_sck_deselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flash_cs_n |-> !flash_sck);

  assert_dummy_lanes_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DUMMY) |-> (flash_io_oe[1:0] == 2'b00));

  assert_single_completion_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_valid, man_done}));

  assert_held_write_keeps_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (man_wr && (state != ST_IDLE)) |=> busy);

endmodule

// File: tb/qspi_flash_ctrl_test.sv
`timescale 1ns/1ps
module qspi_flash_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [17:0] cfg_wdata;
  logic        rd_req;
  logic [23:0] rd_addr;
  logic        rd_ready, rd_valid;
  logic [31:0] rd_data;
  logic        man_cs_en, man_wr;
  logic [7:0]  man_wdata;
  logic        man_done;
  logic [7:0]  man_rdata;
  logic        busy, flash_sck, flash_cs_n;
  logic [3:0]  flash_io_o, flash_io_oe, flash_io_i, drv;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  qspi_flash_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .man_cs_en(man_cs_en), .man_wr(man_wr), .man_wdata(man_wdata),
    .man_done(man_done), .man_rdata(man_rdata), .busy(busy), .flash_sck(flash_sck),
    .flash_cs_n(flash_cs_n), .flash_io_o(flash_io_o), .flash_io_oe(flash_io_oe),
    .flash_io_i(flash_io_i)
  );

  // ---------------- flash model ----------------
  function automatic logic [7:0] fb(logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  function automatic logic [3:0] model_drive(int kk, bit man, int w, int dz, logic [23:0] a);
    logic [31:0] s;
    logic [7:0]  rb;
    logic [3:0]  r;
    int          j;
    r = '0;
    if (man) begin
      rb   = 8'hA0 + 8'(kk / 8);
      r[1] = rb[7 - (kk % 8)];
    end else begin
      j = kk - (8 + 24 / w + dz);
      if (j >= 0 && j * w < 32) begin
        s = {fb(a), fb(a + 24'd1), fb(a + 24'd2), fb(a + 24'd3)};
        s = s << (j * w);
        if (w == 1)      r = {2'b00, s[31], 1'b0};
        else if (w == 2) r = {2'b00, s[31:30]};
        else             r = s[31:28];
      end
    end
    return r;
  endfunction

  int          k = 0, sess_k = 0;
  bit          model_man = 1'b0;
  int          cur_w = 1, cur_dummy = 0;
  logic [7:0]  op_cap = '0, msh = '0;
  logic [23:0] adr_cap = '0;
  logic [7:0]  mcap [4];
  int          dummy_oe_bad = 0, m0_bad = 0, nvalid = 0;
  time         last_rise = 0, per_min = 0, per_max = 0;
  logic        prev_sck = 1'b0;
  logic [3:0]  prev_io = '0;

  assign drv        = flash_cs_n ? 4'b0000 : model_drive(k, model_man, cur_w, cur_dummy, adr_cap);
  assign flash_io_i = (flash_io_oe & flash_io_o) | (~flash_io_oe & drv);

  always @(posedge flash_sck or posedge flash_cs_n) begin
    if (flash_cs_n) begin
      sess_k = k;
      k = 0;
    end else begin
      if (model_man) begin
        msh = {msh[6:0], flash_io_o[0]};
        if (k % 8 == 7) mcap[(k / 8) % 4] = msh;
      end else if (k < 8) begin
        op_cap = {op_cap[6:0], flash_io_o[0]};
      end else if (k < 8 + 24 / cur_w) begin
        if (cur_w == 1)      adr_cap = {adr_cap[22:0], flash_io_o[0]};
        else if (cur_w == 2) adr_cap = {adr_cap[21:0], flash_io_o[1:0]};
        else                 adr_cap = {adr_cap[19:0], flash_io_o};
      end else if (k < 8 + 24 / cur_w + cur_dummy) begin
        if (flash_io_oe[1:0] != 2'b00 || (cur_w == 4 && flash_io_oe != 4'b0000))
          dummy_oe_bad++;
      end
      if (k > 0) begin
        if ($time - last_rise < per_min) per_min = $time - last_rise;
        if ($time - last_rise > per_max) per_max = $time - last_rise;
      end
      last_rise = $time;
      k++;
    end
  end

  // Mode-0 monitor: outputs must hold while SCK stays high (R5).
  always @(negedge clk) begin
    if (rst_n && flash_sck && prev_sck && flash_io_o != prev_io && !flash_cs_n) m0_bad++;
    prev_sck = flash_sck;
    prev_io  = flash_io_o;
    if (rd_valid) nvalid++;
  end

  // ---------------- watchdog ----------------
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog R2 actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_valid();
    int t = 0;
    while (!rd_valid && t < 5000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic wait_man();
    int t = 0;
    while (!man_done && t < 5000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic do_read(input logic [23:0] a, input bit wcfg, input logic [1:0] ln,
                         input logic [3:0] dz, input logic [3:0] hf, input logic [7:0] op);
    int heff;
    if (wcfg) begin
      cfg_we    = 1'b1;
      cfg_wdata = {ln, hf, dz, op};
      @(negedge clk);
      cfg_we    = 1'b0;
    end
    cur_w        = (ln == 2'd0) ? 1 : (ln == 2'd1) ? 2 : 4;
    cur_dummy    = dz;
    model_man    = 1'b0;
    heff         = (hf == 4'd0) ? 1 : hf;
    per_min      = 1000000;
    per_max      = 0;
    dummy_oe_bad = 0;
    rd_req  = 1'b1;
    rd_addr = a;
    @(negedge clk);
    rd_req  = 1'b0;
    wait_valid();
    chk("R2 R11 opcode sent", 32'(op_cap), 32'(op));
    chk("R2 R3 address sent", 32'(adr_cap), 32'(a));
    chk("R2 R3 read word", rd_data, {fb(a + 24'd3), fb(a + 24'd2), fb(a + 24'd1), fb(a)});
    chk("R4 sck period min", 32'(per_min), 32'(2 * heff * 8));
    chk("R4 sck period max", 32'(per_max), 32'(2 * heff * 8));
    @(negedge clk);
    chk("R6 R3 clocks per read", 32'(sess_k), 32'(8 + 24 / cur_w + dz + 32 / cur_w));
    chk("R6 dummy lanes released", 32'(dummy_oe_bad), 32'd0);
  endtask

  // {lanes[1:0], dummy[3:0], half[3:0], opcode[7:0], addr[23:0]}
  localparam logic [41:0] VEC [6] = '{
    {2'd0, 4'd0, 4'd1, 8'h03, 24'h000010},
    {2'd0, 4'd8, 4'd3, 8'h0B, 24'h123456},
    {2'd1, 4'd4, 4'd2, 8'h3B, 24'hABCDEF},
    {2'd2, 4'd6, 4'd1, 8'hEB, 24'h00FFFE},
    {2'd3, 4'd2, 4'd0, 8'h6B, 24'hFEDCBA},
    {2'd2, 4'd0, 4'd2, 8'hEB, 24'h7FFFFD}
  };

  logic [41:0] v;
  int          nv0;

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; rd_req = 1'b0; rd_addr = '0;
    man_cs_en = 1'b0; man_wr = 1'b0; man_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cs idle high", 32'(flash_cs_n), 32'd1);
    chk("R1 sck idle low", 32'(flash_sck), 32'd0);
    chk("R1 not busy", 32'(busy), 32'd0);
    chk("R1 ready", 32'(rd_ready), 32'd1);

    // R1: defaults (single lane, 0x03, no dummy, half 2) without a config write
    do_read(24'h0A0B0C, 1'b0, 2'd0, 4'd0, 4'd2, 8'h03);

    for (int i = 0; i < 6; i++) begin
      v = VEC[i];
      do_read(v[23:0], 1'b1, v[41:40], v[39:36], v[35:32], v[31:24]);
    end

    // R7 R8 R9: manual bytes under held chip select, read request held off
    model_man = 1'b1;
    man_cs_en = 1'b1;
    @(negedge clk);
    chk("R8 cs low on enable", 32'(flash_cs_n), 32'd0);
    chk("R9 ready low while manual", 32'(rd_ready), 32'd0);
    man_wr = 1'b1; man_wdata = 8'h9F;
    @(negedge clk);
    man_wr = 1'b0;
    wait_man();
    chk("R7 first reply", 32'(man_rdata), 32'hA0);
    chk("R7 first byte sent", 32'(mcap[0]), 32'h9F);
    @(negedge clk);
    chk("R8 cs held between bytes", 32'(flash_cs_n), 32'd0);
    nv0 = nvalid;
    rd_req = 1'b1; rd_addr = 24'h111111;
    man_wr = 1'b1; man_wdata = 8'h3C;
    @(negedge clk);
    man_wr = 1'b0;
    wait_man();
    chk("R7 second reply", 32'(man_rdata), 32'hA1);
    chk("R7 second byte sent", 32'(mcap[1]), 32'h3C);
    repeat (20) @(negedge clk);
    chk("R9 stalled read not started", 32'(nvalid - nv0), 32'd0);
    chk("R9 ready low with cs held", 32'(rd_ready), 32'd0);
    rd_req = 1'b0;
    man_cs_en = 1'b0;
    @(negedge clk);
    chk("R8 cs released", 32'(flash_cs_n), 32'd1);

    // R10: manual write posted during a direct read
    model_man = 1'b0;
    rd_req = 1'b1; rd_addr = 24'h2468AC;
    @(negedge clk);
    rd_req = 1'b0;
    man_wr = 1'b1; man_wdata = 8'h77;
    @(negedge clk);
    man_wr = 1'b0;
    chk("R10 busy while held", 32'(busy), 32'd1);
    wait_valid();
    model_man = 1'b1;
    chk("R10 read unaffected", rd_data,
        {fb(24'h2468AF), fb(24'h2468AE), fb(24'h2468AD), fb(24'h2468AC)});
    @(negedge clk);
    wait_man();
    chk("R10 held byte sent", 32'(mcap[0]), 32'h77);
    chk("R10 held byte reply", 32'(man_rdata), 32'hA0);
    @(negedge clk);
    chk("R10 idle after held byte", 32'(busy), 32'd0);

    chk("R5 outputs stable while sck high", 32'(m0_bad), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule